// File: doc/BRIEF.md
# Three-Times Polyphase IIR Interpolator

This block takes a stream of signed 16-bit fixed-point samples at a low rate and produces three output samples for each one, as if the stream had been zero-padded to three times the rate and passed through an IIR low-pass filter. The filter does not run at the high rate. The all-pole part is a chain of three recursive sections, one first-order and two second-order, and it runs once per input sample. Its result goes into three short FIR branches. Branch k holds the numerator taps whose index is k modulo three. All three branches use the same recursive output and are evaluated together when an input is taken.

The three branch results are captured in one register bank. A rotating selector then presents them on three consecutive cycles, in the order branch 0, branch 1, branch 2. The input side uses a valid/ready pair and takes a new sample only when the current burst is about to finish. An input taken during the last output cycle therefore gives a gap-free output stream. All coefficients are fixed by parameters at elaboration time.

Data are Q1.15. Coefficients are Q2.14. Each section and each branch sums its terms exactly in a 36-bit accumulator, then rounds and saturates the result back to 16 bits.

Top module: `ppi3_interp`

## Requirements
- R1: Each sample accepted (in_valid and in_ready both high at a rising clock edge) yields exactly three cycles of out_valid. These start on the cycle after acceptance. out_phase reads 0, 1 and 2 on those cycles, in that order. If no new sample is accepted, out_valid is low afterwards.
- R2: in_ready is high while no burst is running and during the cycle that presents phase 2. It is low during the cycles that present phases 0 and 1. A sample offered while in_ready is low is not taken and changes no later output.
- R3: Output number 3n+k (k = 0, 1, 2) is bit-identical to sample 3n+k of a reference model. The model pads the accepted inputs with two zeros after each sample and applies, at the padded rate, the full filter: the all-pole cascade with its feedback lags tripled, then the full numerator.
- R4: Every section output and every branch output is rounded by adding 2^13 and shifting the 36-bit sum right by 14 bits, arithmetically. The result is clamped to the range -32768 to 32767, and full-scale inputs of either sign follow this rule.
- R5: While rst_n is low, out_valid is 0, in_ready is 1 and out_phase is 0. All filter state is cleared, so the response after reset matches a freshly started reference model.
- R6: Samples offered continuously are accepted once every three cycles. The output then stays valid on every cycle, and all values still match R3.
- R7: out_phase shows the index of the branch whose result is on out_data. It reads 0 whenever out_valid is low.
- R8: Idle cycles between accepted samples do not change the filter state. Results with any spacing of inputs match R3, which counts accepted samples only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, deasserted in step with clk |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample at this edge |
| in_data | input | 16 | Input sample, signed Q1.15 |
| out_valid | output | 1 | out_data holds an output sample |
| out_data | output | 16 | Output sample, signed Q1.15 |
| out_phase | output | 2 | Branch index of the current output sample |

## Verification
The handshake properties assume that in_valid is a known value on every clock edge after reset. They also assume that rst_n is released away from a rising edge, because the flow-control state is meaningful only under those conditions. The stimulus drives in_valid, in_data and rst_n only on falling edges, and it drops in_valid before the edge on which an offered sample must not be taken. The numeric behaviour is not checked by properties. It is checked by comparing every output with a zero-padded high-rate model of the same fixed-point arithmetic. The stimulus includes impulses, full-scale steps of both signs, irregular spacing and continuous streams.

// File: rtl/ppi3_pkg.sv
package ppi3_pkg;
  localparam int DW      = 16;
  localparam int CW      = 16;
  localparam int AW      = 36;
  localparam int FRAC    = 14;
  localparam int PHASES  = 3;
  localparam int PW      = 2;

  typedef logic signed [DW-1:0] samp_t;
  typedef logic signed [CW-1:0] coef_t;
  typedef logic signed [AW-1:0] acc_t;
  typedef logic [PW-1:0]        phase_t;

  localparam acc_t   HALF_LSB  = acc_t'(1) <<< (FRAC - 1);
  localparam acc_t   SAMP_MAX  = (acc_t'(1) <<< (DW - 1)) - acc_t'(1);
  localparam acc_t   SAMP_MIN  = -(acc_t'(1) <<< (DW - 1));
  localparam phase_t LAST_PH   = phase_t'(PHASES - 1);

  // Round half up at the Q2.14 product scale, then clamp into Q1.15.
  function automatic samp_t round_sat(input acc_t a);
    acc_t r;
    r = (a + HALF_LSB) >>> FRAC;
    if (r > SAMP_MAX) return samp_t'(SAMP_MAX);
    if (r < SAMP_MIN) return samp_t'(SAMP_MIN);
    return samp_t'(r);
  endfunction
endpackage

// File: rtl/ppi3_section.sv
module ppi3_section
  import ppi3_pkg::*;
#(
  parameter int    ORDER = 2,
  parameter coef_t A1    = '0,
  parameter coef_t A2    = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  samp_t x_i,
  output samp_t y_o
);
  samp_t y1_q;
  samp_t y1_d;
  acc_t  fb1;
  acc_t  fb2;
  acc_t  acc;

  assign fb1 = acc_t'(A1) * acc_t'(y1_q);

  if (ORDER == 2) begin : g_second
    samp_t y2_q;
    samp_t y2_d;
    assign y2_d = en ? y1_q : y2_q;
    assign fb2  = acc_t'(A2) * acc_t'(y2_q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) y2_q <= '0;
      else        y2_q <= y2_d;
    end
  end else begin : g_first
    assign fb2 = '0;
  end

  always_comb begin
    acc  = (acc_t'(x_i) <<< FRAC) - fb1 - fb2;
    y_o  = round_sat(acc);
    y1_d = en ? y_o : y1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y1_q <= '0;
    else        y1_q <= y1_d;
  end
endmodule

// File: rtl/ppi3_history.sv
module ppi3_history
  import ppi3_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  samp_t d_i,
  output samp_t hist_o [DEPTH]
);
  samp_t q [DEPTH];
  samp_t d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    if (i == 0) begin : g_head
      assign d[i] = en ? d_i : q[i];
    end else begin : g_body
      assign d[i] = en ? q[i-1] : q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= '0;
      else        q[i] <= d[i];
    end
    assign hist_o[i] = q[i];
  end
endmodule

// File: rtl/ppi3_branch.sv
module ppi3_branch
  import ppi3_pkg::*;
#(
  parameter int    TPB  = 3,
  parameter int    K    = 0,
  parameter coef_t COEF [PHASES*TPB] = '{default: '0}
) (
  input  samp_t taps_i [TPB],
  output samp_t y_o
);
  acc_t acc;

  always_comb begin
    acc = '0;
    for (int j = 0; j < TPB; j++) begin
      acc = acc + acc_t'(COEF[PHASES*j + K]) * acc_t'(taps_i[j]);
    end
    y_o = round_sat(acc);
  end
endmodule

// File: rtl/ppi3_commutator.sv
module ppi3_commutator
  import ppi3_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  samp_t  br_i [PHASES],
  output logic   ready_o,
  output logic   valid_o,
  output samp_t  data_o,
  output phase_t phase_o
);
  logic   busy_q, busy_d;
  phase_t ph_q, ph_d;
  samp_t  hold_q [PHASES];
  samp_t  hold_d [PHASES];

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    hold_d = hold_q;
    if (load) begin
      busy_d = 1'b1;
      ph_d   = '0;
      hold_d = br_i;
    end else if (busy_q) begin
      if (ph_q == LAST_PH) begin
        busy_d = 1'b0;
        ph_d   = '0;
      end else begin
        ph_d = ph_q + phase_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      for (int i = 0; i < PHASES; i++) hold_q[i] <= '0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      hold_q <= hold_d;
    end
  end

  assign ready_o = !busy_q || (ph_q == LAST_PH);
  assign valid_o = busy_q;
  assign data_o  = hold_q[ph_q];
  assign phase_o = ph_q;
endmodule

// File: rtl/ppi3_interp.sv
module ppi3_interp
  import ppi3_pkg::*;
#(
  parameter int    TPB   = 3,
  parameter coef_t S1_A1 = -16'sd8192,
  parameter coef_t S2_A1 = -16'sd9830,
  parameter coef_t S2_A2 = 16'sd3277,
  parameter coef_t S3_A1 = 16'sd4915,
  parameter coef_t S3_A2 = 16'sd1638,
  parameter coef_t NUM_COEF [PHASES*TPB] = '{
    16'sd1638, 16'sd3277, 16'sd4915, 16'sd3277, 16'sd1638,
    16'sd819,  16'sd410,  16'sd205,  16'sd102}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data,
  output logic [PW-1:0]        out_phase
);
  localparam int HDEPTH = TPB - 1;

  logic  accept;
  samp_t s1_y, s2_y, s3_y;
  samp_t hist [HDEPTH];
  samp_t taps [TPB];
  samp_t br   [PHASES];

  assign accept = in_valid && in_ready;

  ppi3_section #(.ORDER(1), .A1(S1_A1), .A2('0)) u_sec1 (
    .clk(clk), .rst_n(rst_n), .en(accept), .x_i(in_data), .y_o(s1_y));
  ppi3_section #(.ORDER(2), .A1(S2_A1), .A2(S2_A2)) u_sec2 (
    .clk(clk), .rst_n(rst_n), .en(accept), .x_i(s1_y), .y_o(s2_y));
  ppi3_section #(.ORDER(2), .A1(S3_A1), .A2(S3_A2)) u_sec3 (
    .clk(clk), .rst_n(rst_n), .en(accept), .x_i(s2_y), .y_o(s3_y));

  ppi3_history #(.DEPTH(HDEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n), .en(accept), .d_i(s3_y), .hist_o(hist));

  assign taps[0] = s3_y;
  for (genvar j = 1; j < TPB; j++) begin : g_taps
    assign taps[j] = hist[j-1];
  end

  for (genvar k = 0; k < PHASES; k++) begin : g_branch
    ppi3_branch #(.TPB(TPB), .K(k), .COEF(NUM_COEF)) u_br (
      .taps_i(taps), .y_o(br[k]));
  end

  ppi3_commutator u_comm (
    .clk(clk), .rst_n(rst_n), .load(accept), .br_i(br),
    .ready_o(in_ready), .valid_o(out_valid), .data_o(out_data),
    .phase_o(out_phase));
endmodule

// File: rtl/ppi3_interp_chk.sv
module ppi3_interp_chk
  import ppi3_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic signed [DW-1:0] in_data,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_data,
  input logic [PW-1:0]        out_phase
);
  p_first_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_phase == '0));

  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase != LAST_PH) |=>
      (out_valid && out_phase == $past(out_phase) + 2'd1));

  p_burst_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase == LAST_PH && !(in_valid && in_ready)) |=> !out_valid);

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase != LAST_PH) |-> !in_ready);

  p_idle_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_phase == '0);

  p_phase_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_phase <= LAST_PH);

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !(in_valid && in_ready)) |=> !out_valid);
endmodule

bind ppi3_interp ppi3_interp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
  .out_phase(out_phase));

// File: tb/ppi3_interp_tb.sv
module ppi3_interp_tb;
  localparam logic signed [15:0] A11 = -16'sd8192;
  localparam logic signed [15:0] A21 = -16'sd9830;
  localparam logic signed [15:0] A22 = 16'sd3277;
  localparam logic signed [15:0] A31 = 16'sd4915;
  localparam logic signed [15:0] A32 = 16'sd1638;
  localparam logic signed [15:0] BC [9] = '{
    16'sd1638, 16'sd3277, 16'sd4915, 16'sd3277, 16'sd1638,
    16'sd819,  16'sd410,  16'sd205,  16'sd102};
  localparam int MAXM = 3000;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic in_ready;
  logic signed [15:0] in_data;
  logic out_valid;
  logic signed [15:0] out_data;
  logic [1:0] out_phase;

  int errors = 0;
  int checks = 0;

  longint s1 [MAXM];
  longint s2 [MAXM];
  longint s3 [MAXM];
  int     mcnt = 0;
  longint exp_d [$];
  int     exp_p [$];

  always #5 clk = ~clk;

  ppi3_interp #(
    .TPB(3), .S1_A1(A11), .S2_A1(A21), .S2_A2(A22),
    .S3_A1(A31), .S3_A2(A32), .NUM_COEF(BC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_phase(out_phase));

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Reference rounding/clamp (R4)
  function automatic longint rs(input longint a);
    longint r;
    r = (a + 8192) >>> 14;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic longint at(input longint v [MAXM], input int idx);
    return (idx >= 0) ? v[idx] : 0;
  endfunction

  // Zero-padded high-rate reference (R3)
  task automatic model_push(input longint x);
    for (int p = 0; p < 3; p++) begin
      longint u;
      longint acc;
      int m;
      m = mcnt;
      u = (p == 0) ? x : 0;
      s1[m] = rs((u <<< 14) - longint'(A11) * at(s1, m-3));
      s2[m] = rs((s1[m] <<< 14) - longint'(A21) * at(s2, m-3) - longint'(A22) * at(s2, m-6));
      s3[m] = rs((s2[m] <<< 14) - longint'(A31) * at(s3, m-3) - longint'(A32) * at(s3, m-6));
      acc = 0;
      for (int i = 0; i < 9; i++) acc += longint'(BC[i]) * at(s3, m-i);
      exp_d.push_back(rs(acc));
      exp_p.push_back(p);
      mcnt++;
    end
  endtask

  // Output monitor: every output compared with the model (R3, R4, R6, R8)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (exp_d.size() == 0) begin
        chk(1'b0, "R2 unexpected output", out_data, 0);
      end else begin
        longint ed;
        int ep;
        ed = exp_d.pop_front();
        ep = exp_p.pop_front();
        chk(out_data == ed, "R3 output data", out_data, ed);
        chk(out_phase == ep, "R7 output phase", out_phase, ep);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic send_one(input logic signed [15:0] x);
    in_valid = 1'b1;
    in_data  = x;
    while (in_ready !== 1'b1) @(negedge clk);
    model_push(x);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_d.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle after drain", out_valid, 0);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R5 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R5 in_ready in reset", in_ready, 1);
    chk(out_phase == 2'd0, "R5 out_phase in reset", out_phase, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 idle out_valid", out_valid, 0);
    chk(out_phase == 2'd0, "R7 idle phase zero", out_phase, 0);
  endtask

  task automatic t_burst_shape();
    in_valid = 1'b1; in_data = 16'sd12000;
    model_push(12000);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_phase == 2'd0, "R1 first burst cycle phase 0", out_phase, 0);
    @(negedge clk);
    chk(out_valid && out_phase == 2'd1, "R1 second burst cycle phase 1", out_phase, 1);
    @(negedge clk);
    chk(out_valid && out_phase == 2'd2, "R1 third burst cycle phase 2", out_phase, 2);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 burst ends after three", out_valid, 0);
    chk(out_phase == 2'd0, "R7 phase returns to 0", out_phase, 0);
    drain();
  endtask

  task automatic t_impulse();
    send_one(16'sd16384);
    for (int i = 0; i < 12; i++) send_one(16'sd0);
    drain();
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 20; i++) send_one(16'sd32767);
    for (int i = 0; i < 20; i++) send_one(-16'sd32768);
    for (int i = 0; i < 6; i++) send_one(16'sd0);
    drain();
    chk(1'b1, "R4 full-scale run compared", 0, 0);
  endtask

  task automatic t_stream();
    int gaps;
    gaps = 0;
    for (int i = 0; i < 30; i++) begin
      send_one(16'(i * 2111 - 30000));
      if (out_valid !== 1'b1) gaps++;
    end
    chk(gaps == 0, "R6 no output gap in stream", gaps, 0);
    drain();
  endtask

  task automatic t_spaced();
    for (int i = 0; i < 25; i++) begin
      send_one(16'((i * 7919) % 20000 - 9000));
      repeat (i % 5) @(negedge clk);
    end
    drain();
    chk(1'b1, "R8 spaced inputs compared", 0, 0);
  endtask

  task automatic t_ignored();
    send_one(16'sd5000);
    chk(in_ready == 1'b0, "R2 ready low at phase 0", in_ready, 0);
    in_valid = 1'b1; in_data = 16'sd31111;
    @(negedge clk);
    chk(in_ready == 1'b0, "R2 ready low at phase 1", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b1, "R2 ready high at phase 2", in_ready, 1);
    drain();
    send_one(16'sd0);
    send_one(16'sd0);
    drain();
  endtask

  task automatic t_mid_reset();
    send_one(16'sd20000);
    send_one(-16'sd7000);
    rst_n = 1'b0;
    exp_d.delete();
    exp_p.delete();
    mcnt = 0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 out_valid cleared mid-burst", out_valid, 0);
    chk(in_ready == 1'b1, "R5 in_ready after reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    send_one(16'sd16384);
    for (int i = 0; i < 10; i++) send_one(16'sd0);
    drain();
    chk(1'b1, "R5 fresh response compared", 0, 0);
  endtask

  initial begin
    t_reset_state();
    t_burst_shape();
    t_impulse();
    t_saturate();
    t_stream();
    t_spaced();
    t_ignored();
    t_mid_reset();
    summary();
  end
endmodule